// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and drives a single interrupt line toward a processor. Software sees two byte-wide addresses. Address 0 takes command bytes and returns status. Address 1 takes configuration words while setup is in progress and the mask afterwards. Interrupts are acknowledged by software and not by bus acknowledge cycles. Software first arms a poll with a command byte. The next status read then returns the winning level and moves that level from the request register into the in-service register. Service ends when software writes an end-of-interrupt command.

Several controllers can be chained. A strap input says whether this instance is a slave. A master learns from its setup words which of its inputs carry a slave's output. Those inputs are sampled as levels, so a slave that still has work keeps its request alive after each end-of-interrupt. A slave stores its identity word and treats all of its inputs as edges.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are 0, a status read returns the request register, and int_out is low.
- R2: An address-0 write with bit 4 set starts setup. It clears the mask, request and in-service registers, selects the request register for status reads and cancels an armed poll. The following address-1 writes are taken as a base word, then a link word (skipped when bit 1 of the start byte was 1), then a mode word (taken only when bit 0 of the start byte was 1). None of these writes changes the mask.
- R3: Outside setup, an address-1 write loads the mask and an address-1 read returns it. A set mask bit keeps that level from raising int_out or winning a poll, and the request bit still latches.
- R4: An edge-sensed request bit sets on a rising input and clears as soon as the input is low. A line already high at setup, or held high after its poll, is not seen again until it makes a new rising edge.
- R5: Address-0 write 0x0A selects the request register for status reads and 0x0B selects the in-service register. The choice holds until it is changed.
- R6: Address-0 write 0x0C arms a poll. The next address-0 read returns 0x80 plus the winning level, sets that in-service bit and clears that request bit. Later status reads return the selected register again.
- R7: A poll with no eligible level returns 0x07 and changes no in-service bit.
- R8: Level 0 ranks highest and level 7 lowest. An unmasked request is eligible only when no in-service bit is set at its own level or a higher one.
- R9: int_out is high exactly while an eligible request exists. It rises after the first clock edge that follows an input's rising edge.
- R10: Address-0 write 0x60+n clears in-service bit n and leaves the other bits alone.
- R11: Address-0 write 0x20 clears the highest-priority in-service bit.
- R12: With cfg_slave low, each input whose bit is set in the link word is level-sensed, so its request bit follows the line and comes back after a poll. With cfg_slave high, every input is edge-sensed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 8 | Interrupt request lines, index 0 ranks highest |
| cfg_slave | input | 1 | Strap: high makes this instance a chained slave |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| rd_en | input | 1 | Read strobe; a poll read takes effect at the clock edge |
| port_sel | input | 1 | 0 selects the command/status address, 1 the mask/setup address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid while rd_en is high, 0 otherwise |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
rd_data is combinational from the registers and the strobes, so a read shows its value in the same cycle. Every register effect of a write, a poll or an input edge appears after the next rising clock edge, and int_out follows one edge after an input rises. The bench changes inputs on falling edges and samples one nanosecond before each rising edge. That way each check sees the state left by the previous edge together with the strobes of the current cycle. A behavioural model advances on the same edges and is compared on every cycle. Directed checks wait exactly one edge after a stimulus before they read.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LVL_FIELD_W = 3;

  localparam logic [BYTE_W-1:0] POLL_FOUND_FLAG = 8'h80;
  localparam logic [2:0]        OP_EOI_LEVEL    = 3'b011;
  localparam logic [2:0]        OP_EOI_TOP      = 3'b001;

  // Setup progress: running, or waiting for the base, link or mode word.
  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_LINK = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_t;

  typedef struct packed {
    logic                   start_init;
    logic                   skip_link;
    logic                   want_mode;
    logic                   arm_poll;
    logic                   sel_write;
    logic                   sel_isr;
    logic                   eoi_one;
    logic                   eoi_top;
    logic [LVL_FIELD_W-1:0] lvl;
  } cmd_t;

  // Classify a command-address byte by its field bits.
  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c            = '0;
    c.start_init = b[4];
    c.skip_link  = b[1];
    c.want_mode  = b[0];
    c.lvl        = b[2:0];
    if (!b[4] && b[3]) begin
      c.arm_poll  = b[2];
      c.sel_write = b[1];
      c.sel_isr   = b[0];
    end
    if (!b[4] && !b[3]) begin
      c.eoi_one = (b[7:5] == OP_EOI_LEVEL);
      c.eoi_top = (b[7:5] == OP_EOI_TOP);
    end
    return c;
  endfunction

endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs import pic_pkg::*; #(
  parameter int unsigned N_IN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   port_sel,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic                   poll_take,
  output logic [N_IN-1:0]        mask_q,
  output logic [N_IN-1:0]        link_q,
  output logic                   show_isr_q,
  output logic                   poll_armed_q,
  output logic                   init_fire,
  output logic                   eoi_one_fire,
  output logic                   eoi_top_fire,
  output logic [LVL_FIELD_W-1:0] eoi_lvl
);

  cmd_t       cmd;
  cfg_state_t st_q;
  logic       skip_link_q;
  logic       want_mode_q;
  logic       cmd_wr;
  logic       data_wr;

  assign cmd          = decode_cmd(wr_data);
  assign cmd_wr       = wr_en && !port_sel;
  assign data_wr      = wr_en && port_sel;
  assign init_fire    = cmd_wr && cmd.start_init;
  assign eoi_one_fire = cmd_wr && cmd.eoi_one;
  assign eoi_top_fire = cmd_wr && cmd.eoi_top;
  assign eoi_lvl      = cmd.lvl;

  function automatic cfg_state_t after_base(input logic skip, input logic want);
    if (!skip) return CFG_LINK;
    return want ? CFG_MODE : CFG_RUN;
  endfunction

  function automatic cfg_state_t after_link(input logic want);
    return want ? CFG_MODE : CFG_RUN;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= CFG_RUN;
      mask_q       <= '1;
      link_q       <= '0;
      show_isr_q   <= 1'b0;
      poll_armed_q <= 1'b0;
      skip_link_q  <= 1'b0;
      want_mode_q  <= 1'b0;
    end else begin
      if (poll_take) poll_armed_q <= 1'b0;
      if (init_fire) begin
        st_q         <= CFG_BASE;
        mask_q       <= '0;
        link_q       <= '0;
        show_isr_q   <= 1'b0;
        poll_armed_q <= 1'b0;
        skip_link_q  <= cmd.skip_link;
        want_mode_q  <= cmd.want_mode;
      end else if (cmd_wr) begin
        if (cmd.arm_poll)  poll_armed_q <= 1'b1;
        if (cmd.sel_write) show_isr_q   <= cmd.sel_isr;
      end
      if (data_wr) begin
        case (st_q)
          CFG_RUN:  mask_q <= wr_data[N_IN-1:0];
          CFG_BASE: st_q   <= after_base(skip_link_q, want_mode_q);
          CFG_LINK: begin
            link_q <= wr_data[N_IN-1:0];
            st_q   <= after_link(want_mode_q);
          end
          CFG_MODE: st_q   <= CFG_RUN;
          default:  st_q   <= CFG_RUN;
        endcase
      end
    end
  end

  AST_INIT_OPENS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (mask_q == '0) && (st_q == CFG_BASE)) else $error("setup start"); // R2

  AST_SETUP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CFG_RUN && !init_fire) |=> $stable(mask_q)) else $error("mask moved in setup"); // R2

endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] ir_in,
  input  logic [N_IN-1:0] level_sel,
  input  logic            clear_all,
  input  logic [N_IN-1:0] take_vec,
  output logic [N_IN-1:0] irr_q
);

  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] rise_seen;
  logic [N_IN-1:0] irr_nx;

  assign rise_seen = ir_in & ~prev_q;

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    // A level line mirrors its input; an edge line holds a captured edge while the line stays high.
    assign irr_nx[g] = level_sel[g] ? ir_in[g] : ((irr_q[g] | rise_seen[g]) & ir_in[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      prev_q <= '1;
    end else if (clear_all) begin
      irr_q  <= '0;
      prev_q <= '1;
    end else begin
      irr_q  <= irr_nx & ~take_vec;
      prev_q <= ir_in;
    end
  end

  AST_REQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_all |=> ((irr_q & ~$past(ir_in)) == '0)) else $error("request without line"); // R4

  AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_all |=> (($past(rise_seen & ~take_vec) & ~irr_q) == '0)) else $error("edge lost"); // R4

endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned LVL_W = 3
) (
  input  logic [N_IN-1:0]  irr,
  input  logic [N_IN-1:0]  mask,
  input  logic [N_IN-1:0]  isr,
  output logic             int_req,
  output logic             hit,
  output logic [LVL_W-1:0] hit_lvl,
  output logic [N_IN-1:0]  hit_vec
);

  // Levels strictly above the highest in-service one (all of them when none is in service).
  function automatic logic [N_IN-1:0] open_levels(input logic [N_IN-1:0] svc);
    logic [N_IN-1:0] m;
    logic            blk;
    m   = '0;
    blk = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (svc[i]) blk = 1'b1;
      m[i] = !blk;
    end
    return m;
  endfunction

  function automatic logic [N_IN-1:0] lowest_one(input logic [N_IN-1:0] v);
    return v & (~v + N_IN'(1));
  endfunction

  function automatic logic [LVL_W-1:0] index_of(input logic [N_IN-1:0] onehot);
    logic [LVL_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (onehot[i]) idx = LVL_W'(i);
    end
    return idx;
  endfunction

  logic [N_IN-1:0] eligible;

  assign eligible = irr & ~mask & open_levels(isr);
  assign hit_vec  = lowest_one(eligible);
  assign hit      = |eligible;
  assign hit_lvl  = index_of(hit_vec);
  assign int_req  = hit;

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl import pic_pkg::*; #(
  parameter int unsigned N_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   ir_in,
  input  logic              cfg_slave,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              int_out
);

  localparam int unsigned LVL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [N_IN-1:0]        mask_q;
  logic [N_IN-1:0]        link_q;
  logic                   show_isr_q;
  logic                   poll_armed_q;
  logic                   init_fire;
  logic                   eoi_one_fire;
  logic                   eoi_top_fire;
  logic [LVL_FIELD_W-1:0] eoi_lvl;
  logic [N_IN-1:0]        irr_q;
  logic [N_IN-1:0]        isr_q;
  logic [N_IN-1:0]        level_sel;
  logic [N_IN-1:0]        take_vec;
  logic [N_IN-1:0]        svc_clear;
  logic                   hit;
  logic [LVL_W-1:0]       hit_lvl;
  logic [N_IN-1:0]        hit_vec;
  logic                   int_req;
  logic                   poll_take;
  logic                   poll_hit;

  function automatic logic [N_IN-1:0] lvl_onehot(input logic [LVL_FIELD_W-1:0] l);
    logic [N_IN-1:0] v;
    v = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (l == LVL_FIELD_W'(i)) v[i] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [N_IN-1:0] top_in_service(input logic [N_IN-1:0] v);
    return v & (~v + N_IN'(1));
  endfunction

  // Poll answer: found flag plus level, or the lowest level code with the flag clear.
  function automatic logic [BYTE_W-1:0] poll_word(input logic found, input logic [LVL_W-1:0] lvl);
    logic [BYTE_W-1:0] w;
    w = '0;
    if (found) begin
      w            = POLL_FOUND_FLAG;
      w[LVL_W-1:0] = lvl;
    end else begin
      w[LVL_W-1:0] = LVL_W'(N_IN - 1);
    end
    return w;
  endfunction

  pic_cfg_regs #(.N_IN(N_IN)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .port_sel     (port_sel),
    .wr_data      (wr_data),
    .poll_take    (poll_take),
    .mask_q       (mask_q),
    .link_q       (link_q),
    .show_isr_q   (show_isr_q),
    .poll_armed_q (poll_armed_q),
    .init_fire    (init_fire),
    .eoi_one_fire (eoi_one_fire),
    .eoi_top_fire (eoi_top_fire),
    .eoi_lvl      (eoi_lvl)
  );

  assign level_sel = cfg_slave ? '0 : link_q;
  assign poll_take = rd_en && !port_sel && poll_armed_q;
  assign poll_hit  = poll_take && hit;
  assign take_vec  = poll_hit ? hit_vec : '0;

  pic_req_reg #(.N_IN(N_IN)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_in     (ir_in),
    .level_sel (level_sel),
    .clear_all (init_fire),
    .take_vec  (take_vec),
    .irr_q     (irr_q)
  );

  pic_resolver #(.N_IN(N_IN), .LVL_W(LVL_W)) u_res (
    .irr     (irr_q),
    .mask    (mask_q),
    .isr     (isr_q),
    .int_req (int_req),
    .hit     (hit),
    .hit_lvl (hit_lvl),
    .hit_vec (hit_vec)
  );

  always_comb begin
    svc_clear = '0;
    if (eoi_one_fire)      svc_clear = lvl_onehot(eoi_lvl);
    else if (eoi_top_fire) svc_clear = top_in_service(isr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         isr_q <= '0;
    else if (init_fire) isr_q <= '0;
    else                isr_q <= (isr_q & ~svc_clear) | take_vec;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (port_sel)          rd_data = BYTE_W'(mask_q);
      else if (poll_armed_q) rd_data = poll_word(hit, hit_lvl);
      else if (show_isr_q)   rd_data = BYTE_W'(isr_q);
      else                   rd_data = BYTE_W'(irr_q);
    end
  end

  assign int_out = int_req;

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != '0)) else $error("int without request"); // R9

  AST_POLL_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_hit && !init_fire) |=> isr_q[$past(hit_lvl)]) else $error("poll lost"); // R6

  AST_POLL_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !hit && !wr_en) |=> $stable(isr_q)) else $error("miss changed service"); // R7

  AST_EOI_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_one_fire && !poll_hit) |=> !isr_q[$past(eoi_lvl)]) else $error("eoi ignored"); // R10

  AST_NO_OUTRANKED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((isr_q & (hit_vec | (hit_vec - N_IN'(1)))) == '0)) else $error("outranked hit"); // R8

  AST_SVC_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_fire |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1)) else $error("service burst"); // R8

endmodule

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = 8'h00;
  logic       cfg_slave = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       port_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       int_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pic_ctrl i_pic_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_in     (ir),
    .cfg_slave (cfg_slave),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .int_out   (int_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mask, m_isr, m_irr, m_prev, m_link, m_show, m_poll, m_phase, m_skip, m_want;

  // Walk from the top priority down; an in-service level stops the search.
  function automatic int m_pick(input int irr, input int mask, input int isr);
    for (int i = 0; i < 8; i++) begin
      if (((isr >> i) & 1) == 1) return -1;
      if ((((irr & ~mask) >> i) & 1) == 1) return i;
    end
    return -1;
  endfunction

  function automatic int m_read();
    int p;
    if (!rd_en) return 0;
    if (port_sel) return m_mask;
    if (m_poll != 0) begin
      p = m_pick(m_irr, m_mask, m_isr);
      return (p >= 0) ? 128 + p : 7;
    end
    return (m_show != 0) ? m_isr : m_irr;
  endfunction

  always @(posedge clk) begin : model_step
    int nirr;
    int p;
    if (!rst_n) begin
      m_mask = 255; m_isr = 0; m_irr = 0; m_prev = 255; m_link = 0;
      m_show = 0; m_poll = 0; m_phase = 0; m_skip = 0; m_want = 0;
    end else begin
      nirr = 0;
      for (int i = 0; i < 8; i++) begin
        bit hi;
        bit lvl;
        hi  = ir[i];
        lvl = !cfg_slave && (((m_link >> i) & 1) == 1);
        if (lvl) begin
          if (hi) nirr |= (1 << i);
        end else if (hi && ((((m_irr >> i) & 1) == 1) || (((m_prev >> i) & 1) == 0))) begin
          nirr |= (1 << i);
        end
      end
      m_prev = ir;
      if (rd_en && !port_sel && m_poll != 0) begin
        p = m_pick(m_irr, m_mask, m_isr);
        m_poll = 0;
        if (p >= 0) begin
          m_isr |= (1 << p);
          nirr &= ~(1 << p);
        end
      end
      if (wr_en && !port_sel) begin
        if (wr_data[4]) begin
          m_mask = 0; m_isr = 0; nirr = 0; m_prev = 255; m_link = 0; m_show = 0; m_poll = 0;
          m_skip = wr_data[1]; m_want = wr_data[0]; m_phase = 1;
        end else if (wr_data[3]) begin
          if (wr_data[2]) m_poll = 1;
          if (wr_data[1]) m_show = wr_data[0];
        end else if (wr_data[7:5] == 3'd3) begin
          m_isr &= ~(1 << wr_data[2:0]);
        end else if (wr_data[7:5] == 3'd1) begin
          for (int i = 0; i < 8; i++) begin
            if (((m_isr >> i) & 1) == 1) begin
              m_isr &= ~(1 << i);
              break;
            end
          end
        end
      end
      if (wr_en && port_sel) begin
        case (m_phase)
          0: m_mask = wr_data;
          1: m_phase = (m_skip != 0) ? ((m_want != 0) ? 3 : 0) : 2;
          2: begin m_link = wr_data; m_phase = (m_want != 0) ? 3 : 0; end
          default: m_phase = 0;
        endcase
      end
      m_irr = nirr;
    end
  end

  // Compare the design with the model just before every rising edge.
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      chk(rd_data == 8'(m_read()), "R6 model rd_data", rd_data, m_read());
      chk(int_out == (m_pick(m_irr, m_mask, m_isr) >= 0), "R9 model int_out",
          int_out, m_pick(m_irr, m_mask, m_isr) >= 0);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    port_sel = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    port_sel = a; rd_en = 1'b1;
    #3;
    chk(rd_data == exp, tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_ir(input logic [7:0] v);
    @(negedge clk);
    ir = v;
  endtask

  task automatic chk_int(input bit exp, input string tag);
    @(negedge clk);
    #3;
    chk(int_out == exp, tag, int_out, exp);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b1, 8'hFF, "R1 mask after reset");
    rd(1'b0, 8'h00, "R1 request after reset");
    chk_int(1'b0, "R1 int after reset");

    // R2 full setup as master, input 2 linked
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R2 mask cleared by setup");
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R3 mask readback");

    // R4 edge capture and drop
    set_ir(8'h01);
    chk_int(1'b1, "R9 int one edge after rise");
    rd(1'b0, 8'h01, "R4 request latched");
    set_ir(8'h00);
    rd(1'b0, 8'h00, "R4 request dropped with line");
    chk_int(1'b0, "R9 int low without request");

    // R3 masked line latches but stays quiet
    set_ir(8'h10);
    chk_int(1'b0, "R3 masked line no int");
    rd(1'b0, 8'h10, "R3 masked request still latched");
    set_ir(8'h00);

    // R6 poll
    set_ir(8'h28);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h83, "R6 poll returns level 3");
    rd(1'b0, 8'h20, "R6 polled request cleared, held edge not relatched (R4)");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R5 in-service select");
    rd(1'b0, 8'h08, "R5 select persists");

    // R8 nesting
    wr(1'b1, 8'h00);
    chk_int(1'b0, "R8 lower level blocked by in-service");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h07, "R7 empty poll code");
    rd(1'b0, 8'h08, "R7 in-service unchanged");
    set_ir(8'h2A);
    chk_int(1'b1, "R8 higher level passes");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h81, "R8 poll picks level 1");
    rd(1'b0, 8'h0A, "R8 two levels in service");

    // R11 / R10 end of interrupt
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R11 top in-service cleared");
    chk_int(1'b0, "R8 level 5 still blocked");
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h00, "R10 level 3 cleared");
    chk_int(1'b1, "R9 level 5 now eligible");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R6 poll level 5");
    wr(1'b0, 8'h67);
    rd(1'b0, 8'h20, "R10 other bits kept");
    wr(1'b0, 8'h65);
    rd(1'b0, 8'h00, "R10 level 5 cleared");

    // R12 linked input is level sensed in master mode
    set_ir(8'h04);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R12 poll linked level 2");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h04, "R12 linked request returns after poll");
    wr(1'b0, 8'h62);
    chk_int(1'b1, "R12 held linked line raises int again");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R12 second poll without new edge");
    wr(1'b0, 8'h62);
    set_ir(8'h00);

    // R12 slave mode: all edges
    @(negedge clk); cfg_slave = 1'b1;
    set_ir(8'h04);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R12 slave poll level 2");
    rd(1'b0, 8'h00, "R12 slave held line not relatched");
    wr(1'b0, 8'h62);

    // R2 short setup: link word skipped, mode word taken
    wr(1'b0, 8'h13); wr(1'b1, 8'h08); wr(1'b1, 8'h01);
    rd(1'b0, 8'h00, "R4 held line ignored after setup");
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, "R2 link word skipped");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R2 in-service cleared");
    set_ir(8'h00);
    @(negedge clk); cfg_slave = 1'b0;

    // mixed stimulus checked against the model each cycle
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
    for (int k = 0; k < 3000; k++) begin
      int act;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (($urandom % 4) == 0) ir = ir ^ (8'h01 << ($urandom % 8));
      act = $urandom % 8;
      case (act)
        0: begin
          wr_en = 1'b1; port_sel = 1'b0;
          case ($urandom % 5)
            0: wr_data = 8'h0A;
            1: wr_data = 8'h0B;
            2: wr_data = 8'h0C;
            3: wr_data = 8'h20;
            default: wr_data = 8'h60 + 8'($urandom % 8);
          endcase
        end
        1: begin wr_en = 1'b1; port_sel = 1'b1; wr_data = 8'($urandom % 4) & 8'h33; end
        2, 3: begin rd_en = 1'b1; port_sel = 1'b0; end
        4: begin rd_en = 1'b1; port_sel = 1'b1; end
        5: begin wr_en = 1'b1; port_sel = 1'b0; wr_data = 8'h0C; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule